// File: doc/BRIEF.md
# Photomultiplier Pulse Classifier

This block sits behind two comparators watching a photomultiplier signal: a low-threshold comparator set near a quarter of a single-photoelectron amplitude, and a high-threshold comparator on the dynode set near five photoelectrons. A rising edge on the low comparator marks the start of a pulse. The block answers with a one-cycle start strobe and opens a decision window whose length is a count of fast-clock cycles. The default is 12 cycles, which is 60 ns at 200 MHz.

When the window closes, the block gives a one-cycle classification strobe. It comes with a three-bit reason code, a non-single-photoelectron flag and a two-bit readout selection (anode or dynode). A pulse is non-single-photoelectron when any of three things happens: a second hit falls inside the window, the pulse is still above the low threshold when the window closes, or the high threshold was crossed. Hits that arrive while a window is open add to the current pulse and do not restart the window.

The two five-bit threshold codes for the external DACs and the window length are loaded through a 16-bit serial register. That register has data, enable, shift and clear lines, all sampled in the core clock domain. The new settings take effect when the enable line drops. The comparator inputs are expected to be synchronous to the core clock.

Top module: `pmt_pulse_classifier`

## Requirements
- R1: While reset is held and after it, the low-threshold code is 4, the high-threshold code is 20 and the window length is 12. The start, classification, non-single-photoelectron, reason and selection outputs are all 0.
- R2: Suppose the block is idle and a clock edge samples the low comparator high after it was low at the edge before. Then `start_o` is high for exactly the following cycle. A rising edge on the low comparator while a window is open raises no start.
- R3: With a window of W cycles, `class_valid_o` is high for exactly one cycle, W cycles after the cycle in which `start_o` was high. The window length is taken when the pulse starts.
- R4: Reason bit 0 (second hit) is set when a new rising edge of the low comparator is sampled at any of the W edges that follow the start edge.
- R5: Reason bit 1 (too long) is set when the low comparator is still high at the edge that closes the window.
- R6: Reason bit 2 (high threshold) is set when the high comparator is sampled high at the start edge or at any of the W edges after it.
- R7: `nspe_o` is the OR of the three reason bits. `sel_o` is 2'b10 (dynode) when reason bit 2 is set and 2'b01 (anode) otherwise. Reason, flag and selection hold their values until the next classification.
- R8: Each cycle with both `sc_en_i` and `sc_shift_i` high shifts `sc_data_i` into bit 0 of the 16-bit register, so the first bit sent ends up in bit 15. Bits [15:11] are the low-threshold code, [10:6] the high-threshold code and [5:0] the window length. All three take effect at the first edge that samples `sc_en_i` low after it was high.
- R9: Shift pulses while `sc_en_i` is low leave the register unchanged. The active settings do not change while `sc_en_i` stays high.
- R10: `sc_clear_i` sets the shift register to zero. A loaded window length of 0 acts as a window of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (fast) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_cmp_i | input | 1 | Low-threshold comparator output |
| hi_cmp_i | input | 1 | High-threshold (dynode) comparator output |
| sc_data_i | input | 1 | Serial configuration data bit |
| sc_shift_i | input | 1 | Shift strobe, one core cycle per bit |
| sc_en_i | input | 1 | Serial load enable; its falling edge applies the settings |
| sc_clear_i | input | 1 | Clears the serial shift register |
| start_o | output | 1 | Pulse start strobe |
| class_valid_o | output | 1 | Classification strobe at the end of the window |
| nspe_o | output | 1 | Non-single-photoelectron flag |
| reason_o | output | 3 | {high threshold, too long, second hit} |
| sel_o | output | 2 | Readout selection: 01 anode, 10 dynode |
| thr_lo_code_o | output | 5 | Low-threshold DAC code |
| thr_hi_code_o | output | 5 | High-threshold DAC code |

## Verification
The bench builds the block with its default widths: five-bit threshold codes and a six-bit window field, so windows from 1 to 63 cycles can be set. At that size, the whole serial register can be loaded in 16 shifts. The bench covers randomly chosen windows between 1 and 40 cycles, the zero-window case reached through clear, and the default 12-cycle window. That range is small enough for every edge inside a window to be driven and checked, including a second hit or a still-high comparator exactly on the closing edge.

// File: rtl/pmtc_pkg.sv
package pmtc_pkg;
  parameter int CODE_W = 5;
  parameter int WIN_W  = 6;
  localparam int SREG_W = 2 * CODE_W + WIN_W;
  localparam int RSN_W  = 3;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_ANODE = 2'b01;
  localparam logic [SEL_W-1:0] SEL_DYN   = 2'b10;

  typedef struct packed {
    logic [CODE_W-1:0] thr_lo;
    logic [CODE_W-1:0] thr_hi;
    logic [WIN_W-1:0]  win;
  } cfg_t;
endpackage

// File: rtl/pmtc_cfg_sreg.sv
module pmtc_cfg_sreg
  import pmtc_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEF_THR_LO = 5'd4,
  parameter logic [CODE_W-1:0] DEF_THR_HI = 5'd20,
  parameter logic [WIN_W-1:0]  DEF_WIN    = 6'd12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_data,
  input  logic sc_shift,
  input  logic sc_en,
  input  logic sc_clear,
  output cfg_t cfg_o
);
  localparam cfg_t RST_CFG = '{thr_lo: DEF_THR_LO, thr_hi: DEF_THR_HI, win: DEF_WIN};

  logic [SREG_W-1:0] sreg_q, sreg_d;
  logic              en_q;
  cfg_t              cfg_q, cfg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (sc_clear) begin
      sreg_d = '0;
    end else if (sc_en && sc_shift) begin
      sreg_d = {sreg_q[SREG_W-2:0], sc_data};
    end
  end

  always_comb begin
    cfg_d = cfg_q;
    if (en_q && !sc_en) begin
      cfg_d = cfg_t'(sreg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      en_q   <= 1'b0;
      cfg_q  <= RST_CFG;
    end else begin
      sreg_q <= sreg_d;
      en_q   <= sc_en;
      cfg_q  <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pmtc_rise_det.sv
module pmtc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i && !lvl_q;
endmodule

// File: rtl/pmtc_window.sv
module pmtc_window
  import pmtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_lvl_i,
  input  logic             lo_rise_i,
  input  logic             hi_lvl_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             start_o,
  output logic             valid_o,
  output logic             nspe_o,
  output logic [RSN_W-1:0] reason_o,
  output logic [SEL_W-1:0] sel_o
);
  logic             busy_q, busy_d;
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             more_q, more_d;
  logic             hi_q, hi_d;
  logic             start_q, start_d;
  logic             valid_q, valid_d;
  logic             nspe_q, nspe_d;
  logic [RSN_W-1:0] rsn_q, rsn_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [WIN_W-1:0] win_eff;
  logic             more_nx, hi_nx;

  assign win_eff = (win_len_i == '0) ? WIN_W'(1) : win_len_i;
  assign more_nx = more_q || lo_rise_i;
  assign hi_nx   = hi_q || hi_lvl_i;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    more_d  = more_q;
    hi_d    = hi_q;
    start_d = 1'b0;
    valid_d = 1'b0;
    nspe_d  = nspe_q;
    rsn_d   = rsn_q;
    sel_d   = sel_q;
    if (!busy_q) begin
      if (lo_rise_i) begin
        busy_d  = 1'b1;
        start_d = 1'b1;
        cnt_d   = win_eff - WIN_W'(1);
        more_d  = 1'b0;
        hi_d    = hi_lvl_i;
      end
    end else if (cnt_q == '0) begin
      busy_d  = 1'b0;
      valid_d = 1'b1;
      rsn_d   = {hi_nx, lo_lvl_i, more_nx};
      nspe_d  = hi_nx || lo_lvl_i || more_nx;
      sel_d   = hi_nx ? SEL_DYN : SEL_ANODE;
    end else begin
      cnt_d  = cnt_q - WIN_W'(1);
      more_d = more_nx;
      hi_d   = hi_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      more_q  <= 1'b0;
      hi_q    <= 1'b0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
      nspe_q  <= 1'b0;
      rsn_q   <= '0;
      sel_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      more_q  <= more_d;
      hi_q    <= hi_d;
      start_q <= start_d;
      valid_q <= valid_d;
      nspe_q  <= nspe_d;
      rsn_q   <= rsn_d;
      sel_q   <= sel_d;
    end
  end

  assign start_o  = start_q;
  assign valid_o  = valid_q;
  assign nspe_o   = nspe_q;
  assign reason_o = rsn_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/pmt_pulse_classifier.sv
module pmt_pulse_classifier
  import pmtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_cmp_i,
  input  logic              hi_cmp_i,
  input  logic              sc_data_i,
  input  logic              sc_shift_i,
  input  logic              sc_en_i,
  input  logic              sc_clear_i,
  output logic              start_o,
  output logic              class_valid_o,
  output logic              nspe_o,
  output logic [RSN_W-1:0]  reason_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CODE_W-1:0] thr_lo_code_o,
  output logic [CODE_W-1:0] thr_hi_code_o
);
  cfg_t cfg;
  logic lo_rise;

  pmtc_cfg_sreg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc_data  (sc_data_i),
    .sc_shift (sc_shift_i),
    .sc_en    (sc_en_i),
    .sc_clear (sc_clear_i),
    .cfg_o    (cfg)
  );

  pmtc_rise_det u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lo_cmp_i),
    .rise_o (lo_rise)
  );

  pmtc_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_lvl_i  (lo_cmp_i),
    .lo_rise_i (lo_rise),
    .hi_lvl_i  (hi_cmp_i),
    .win_len_i (cfg.win),
    .start_o   (start_o),
    .valid_o   (class_valid_o),
    .nspe_o    (nspe_o),
    .reason_o  (reason_o),
    .sel_o     (sel_o)
  );

  assign thr_lo_code_o = cfg.thr_lo;
  assign thr_hi_code_o = cfg.thr_hi;
endmodule

// File: rtl/pmt_pulse_classifier_chk.sv
module pmt_pulse_classifier_chk
  import pmtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              lo_cmp_i,
  input logic              sc_en_i,
  input logic              start_o,
  input logic              class_valid_o,
  input logic              nspe_o,
  input logic [RSN_W-1:0]  reason_o,
  input logic [SEL_W-1:0]  sel_o,
  input logic [CODE_W-1:0] thr_lo_code_o,
  input logic [CODE_W-1:0] thr_hi_code_o
);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($past(lo_cmp_i) && !$past(lo_cmp_i, 2)));

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |=> !class_valid_o);

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && class_valid_o));

  // R7
  nspe_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |-> (nspe_o == (reason_o != '0)));

  // R7
  sel_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid_o |-> (sel_o == (reason_o[2] ? SEL_DYN : SEL_ANODE)));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !class_valid_o |-> $stable(sel_o));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_en_i && $past(sc_en_i)) |-> ($stable(thr_lo_code_o) && $stable(thr_hi_code_o)));
endmodule

bind pmt_pulse_classifier pmt_pulse_classifier_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lo_cmp_i      (lo_cmp_i),
  .sc_en_i       (sc_en_i),
  .start_o       (start_o),
  .class_valid_o (class_valid_o),
  .nspe_o        (nspe_o),
  .reason_o      (reason_o),
  .sel_o         (sel_o),
  .thr_lo_code_o (thr_lo_code_o),
  .thr_hi_code_o (thr_hi_code_o)
);

// File: tb/pmt_pulse_classifier_tb.sv
module pmt_pulse_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_cmp_i, hi_cmp_i, sc_data_i, sc_shift_i, sc_en_i, sc_clear_i;
  logic       start_o, class_valid_o, nspe_o;
  logic [2:0] reason_o;
  logic [1:0] sel_o;
  logic [4:0] thr_lo_code_o, thr_hi_code_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_win = 12;
  logic [4:0] cur_lo = 5'd4;
  logic [4:0] cur_hi = 5'd20;
  logic [1:0] prev_sel = 2'b00;

  always #4 clk = ~clk;

  pmt_pulse_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .lo_cmp_i(lo_cmp_i), .hi_cmp_i(hi_cmp_i),
    .sc_data_i(sc_data_i), .sc_shift_i(sc_shift_i), .sc_en_i(sc_en_i),
    .sc_clear_i(sc_clear_i), .start_o(start_o), .class_valid_o(class_valid_o),
    .nspe_o(nspe_o), .reason_o(reason_o), .sel_o(sel_o),
    .thr_lo_code_o(thr_lo_code_o), .thr_hi_code_o(thr_hi_code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [2:0] exp_reason(input logic [63:0] p, input logic [63:0] h, input int w);
    logic more = 1'b0;
    logic hs   = h[0];
    for (int k = 1; k <= w; k++) begin
      if (p[k] && !p[k-1]) more = 1'b1;
      if (h[k]) hs = 1'b1;
    end
    return {hs, p[w], more};
  endfunction

  // Drives one pulse from idle; bit k of p/h is sampled at the k-th edge after the start edge.
  task automatic run_pulse(input logic [63:0] p, input logic [63:0] h, input string tag);
    int w = cur_win;
    logic [2:0] er = exp_reason(p, h, w);
    logic [1:0] es = er[2] ? 2'b10 : 2'b01;
    for (int k = 0; k <= w + 2; k++) begin
      lo_cmp_i = (k <= w) ? p[k] : 1'b0;
      hi_cmp_i = (k <= w) ? h[k] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(start_o == (k == 0), {"R2 start ", tag}, int'(start_o), int'(k == 0));
      chk(class_valid_o == (k == w), {"R3 valid ", tag}, int'(class_valid_o), int'(k == w));
      if (k < w) chk(sel_o == prev_sel, {"R7 hold ", tag}, int'(sel_o), int'(prev_sel));
      if (k == w) begin
        chk(reason_o[0] == er[0], {"R4 second hit ", tag}, int'(reason_o[0]), int'(er[0]));
        chk(reason_o[1] == er[1], {"R5 too long ", tag}, int'(reason_o[1]), int'(er[1]));
        chk(reason_o[2] == er[2], {"R6 high thr ", tag}, int'(reason_o[2]), int'(er[2]));
        chk(nspe_o == (er != 3'b0), {"R7 nspe ", tag}, int'(nspe_o), int'(er != 3'b0));
        chk(sel_o == es, {"R7 sel ", tag}, int'(sel_o), int'(es));
        prev_sel = es;
      end
    end
  endtask

  task automatic sc_load(input logic [4:0] lo, input logic [4:0] hi, input logic [5:0] win);
    logic [15:0] v = {lo, hi, win};
    sc_en_i = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      sc_data_i  = v[i];
      sc_shift_i = 1'b1;
      @(negedge clk);
    end
    sc_shift_i = 1'b0;
    @(negedge clk);
    chk(thr_lo_code_o == cur_lo && thr_hi_code_o == cur_hi, "R9 no change while enabled",
        int'(thr_lo_code_o), int'(cur_lo));
    sc_en_i = 1'b0;
    @(negedge clk);
    chk(thr_lo_code_o == lo, "R8 low code applied", int'(thr_lo_code_o), int'(lo));
    chk(thr_hi_code_o == hi, "R8 high code applied", int'(thr_hi_code_o), int'(hi));
    cur_lo  = lo;
    cur_hi  = hi;
    cur_win = (win == 6'd0) ? 1 : int'(win);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; lo_cmp_i = 0; hi_cmp_i = 0;
    sc_data_i = 0; sc_shift_i = 0; sc_en_i = 0; sc_clear_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(thr_lo_code_o == 5'd4, "R1 low code", int'(thr_lo_code_o), 4);
    chk(thr_hi_code_o == 5'd20, "R1 high code", int'(thr_hi_code_o), 20);
    chk({start_o, class_valid_o, nspe_o, reason_o, sel_o} == 8'd0, "R1 outputs",
        int'({start_o, class_valid_o, nspe_o, reason_o, sel_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed, default window of 12 (R1, R3)
    run_pulse(64'h7, 64'h0, "clean");
    run_pulse(64'h1FFF, 64'h0, "long");
    run_pulse(64'h33, 64'h0, "double");
    run_pulse(64'h3, 64'h400, "high late");
    run_pulse(64'h1001, 64'h0, "rise on close edge");
    run_pulse(64'h1, 64'h1, "high at start");

    // R9: shift pulses with enable low are ignored
    sc_load(5'd9, 5'd27, 6'd5);
    sc_data_i = 1'b1;
    sc_shift_i = 1'b1;
    repeat (16) @(negedge clk);
    sc_shift_i = 1'b0;
    sc_en_i = 1'b1;
    @(negedge clk);
    sc_en_i = 1'b0;
    @(negedge clk);
    chk(thr_lo_code_o == 5'd9, "R9 shift ignored", int'(thr_lo_code_o), 9);
    run_pulse(64'h3F, 64'h0, "win5 long");

    // R10: clear then apply gives zero codes and a 1-cycle window
    sc_en_i = 1'b1;
    sc_data_i = 1'b1;
    sc_shift_i = 1'b1;
    repeat (3) @(negedge clk);
    sc_shift_i = 1'b0;
    sc_clear_i = 1'b1;
    @(negedge clk);
    sc_clear_i = 1'b0;
    sc_en_i = 1'b0;
    @(negedge clk);
    chk(thr_lo_code_o == 5'd0 && thr_hi_code_o == 5'd0, "R10 clear codes",
        int'({thr_lo_code_o, thr_hi_code_o}), 0);
    cur_lo = 5'd0; cur_hi = 5'd0; cur_win = 1;
    run_pulse(64'h1, 64'h0, "R10 window one");
    run_pulse(64'h3, 64'h0, "R10 window one long");

    // Random configurations and pulses (R4 R5 R6)
    for (int c = 0; c < 8; c++) begin
      sc_load(5'($urandom), 5'($urandom), 6'(1 + $urandom % 40));
      for (int n = 0; n < 10; n++) begin
        logic [63:0] p;
        logic [63:0] h = 64'h0;
        if ($urandom % 3 == 0) p = (64'h1 << (1 + $urandom % (cur_win + 1))) - 64'h1;
        else p = {$urandom, $urandom} | 64'h1;
        if ($urandom % 3 == 0) h = 64'h1 << ($urandom % (cur_win + 1));
        run_pulse(p, h, "random");
      end
    end

    summary();
    $finish;
  end
endmodule